// File: doc/BRIEF.md
# Digital Audio Subframe Formatter and Biphase-Mark Encoder

This block is the transmit formatter of a two-channel serial digital audio link. Once per frame it takes a left and a right sample word, with a validity bit and a user bit for each channel and one channel-status bit for the frame. It lays these out as two 32-bit subframes, adds a sync preamble and an even-parity bit to each, and sends the result as a biphase-mark coded line signal. The line signal comes out as a complementary pair, ready for a differential line driver.

The whole block runs from one master clock at 128 times the sample rate. One clock cycle is one biphase half-cell, so a frame lasts exactly 128 cycles. For example, 44.1 kHz audio needs a 5.6448 MHz clock. The block pulses `sample_take` in the last cycle of each frame, and the inputs present in that cycle are sent in the next frame. Sample words may carry 16 to 24 significant bits, aligned to the MSB. A word-length input clears the unused low-order bits. Channel status is sent one bit per frame across a 192-frame block. The block forces the first bit of each block to the professional/consumer selection. In professional mode it can also replace the last status byte with a CRC that it computes itself.

Top module: `aes_subframe_tx`

## Requirements
- R1: A frame is exactly 128 clock cycles. `sample_take` is high for one cycle, in the last cycle of each frame. The sample, validity, user, status and word-length inputs present in that cycle are sent in the following frame.
- R2: Each subframe holds, in transmission order: slots 0-3 preamble, slots 4-27 the audio word LSB first (word bit 0 in slot 4), slot 28 validity, slot 29 user, slot 30 channel status, slot 31 parity. The left subframe comes first in each frame.
- R3: With word length W, audio bits 0 to 23-W are sent as zero. W values below 16 act as 16, and values above 24 act as 24.
- R4: The parity slot makes the number of ones in slots 4-31 of each subframe even.
- R5: In slots 4-31 the line level changes at the start of every cell. It changes again at mid-cell only when the bit is a one.
- R6: Each preamble spans eight half-cells. The half-cell levels are 11101000 for a block start, 11100010 for other left subframes and 11100100 for right subframes (leftmost first). The whole pattern is inverted when the line was high just before it. A block start is every 192nd frame.
- R7: Each frame sends one channel-status bit, and the same value goes in both subframes. The status bit index is 0 in a block-start frame and counts up by one per frame.
- R8: Status bit 0 of every block equals `pro_mode`, whatever `cs_bit` was.
- R9: When `pro_mode` and `crc_en` are both high, status bits 184-191 send CRC register bit k at index 184+k. The CRC is an 8-bit register preset to 0xFF at each block start. It takes status bits 0-183 as sent, in order: feedback = reg[7] xor bit, and reg becomes (reg<<1) xor (feedback ? 0x1D : 0), which is the polynomial x^8+x^4+x^3+x^2+1.
- R10: When `pro_mode` or `crc_en` is low, status bits 184-191 carry `cs_bit` unchanged.
- R11: During reset `line_p` is 0, `line_n` is 1 and `sample_take` is 0. The first frame after reset is a block start with all data slots zero, apart from status bit 0.
- R12: `line_n` is always the complement of `line_p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 128 cycles per frame |
| rst_n | input | 1 | Active-low synchronous reset |
| pro_mode | input | 1 | 1 = professional, 0 = consumer |
| crc_en | input | 1 | Enables the internal status CRC in professional mode |
| word_len | input | 5 | Significant bits in the sample words (16 to 24) |
| left_sample | input | 24 | Left sample, MSB-aligned |
| right_sample | input | 24 | Right sample, MSB-aligned |
| left_valid | input | 1 | Validity bit for the left subframe |
| right_valid | input | 1 | Validity bit for the right subframe |
| left_user | input | 1 | User bit for the left subframe |
| right_user | input | 1 | User bit for the right subframe |
| cs_bit | input | 1 | Channel-status bit for the frame |
| sample_take | output | 1 | High in the cycle where the frame inputs are latched |
| line_p | output | 1 | Biphase-mark line signal |
| line_n | output | 1 | Complement of line_p |

## Verification
The bench decodes every half-cell of the line signal over several whole 192-frame blocks, in three mode settings, and compares each decoded field with values it computes itself. It targets these faults:
- A preamble whose polarity does not follow the previous line level shows up as a pattern mismatch.
- An off-by-one in the frame counter puts the block-start preamble in the wrong place.
- A parity calculation that leaves out the status bit fails the even-parity check.
- A status CRC that is preset, fed or frozen wrongly corrupts bits 184-191.
- A word-length mask that is not clamped lets low-order bits through, or clears too many of them.
- A mistake in the consumer or CRC-disabled path puts the CRC where `cs_bit` should pass straight through.

// File: rtl/aes_tx_pkg.sv
package aes_tx_pkg;

    localparam int PRE_BITS   = 4;
    localparam int AUX_BITS   = 4;
    localparam int PRE_HALVES = 2 * PRE_BITS;

    typedef enum logic [1:0] {
        PRE_BLOCK = 2'd0,
        PRE_LEFT  = 2'd1,
        PRE_RIGHT = 2'd2
    } pre_kind_e;

    // Half-cell levels of each sync pattern, leftmost sent first, for a low prior line
    function automatic logic [PRE_HALVES-1:0] preamble_pattern(pre_kind_e kind);
        case (kind)
            PRE_BLOCK: return 8'b1110_1000;
            PRE_LEFT:  return 8'b1110_0010;
            default:   return 8'b1110_0100;
        endcase
    endfunction

endpackage

// File: rtl/aes_frame_timer.sv
module aes_frame_timer #(
    parameter int FRAME_HALVES = 128,
    parameter int BLOCK_FRAMES = 192,
    localparam int HW = $clog2(FRAME_HALVES),
    localparam int FW = $clog2(BLOCK_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] half_cnt,
    output logic [FW-1:0] frame_idx,
    output logic          take,
    output logic          block_wrap
);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic [FW-1:0] frame;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        take     = (st_q.cnt == HW'(FRAME_HALVES - 1));
        block_wrap = take && (st_q.frame == FW'(BLOCK_FRAMES - 1));
        st_d.cnt = take ? '0 : st_q.cnt + 1'b1;
        if (take) begin
            st_d.frame = block_wrap ? '0 : st_q.frame + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign half_cnt  = st_q.cnt;
    assign frame_idx = st_q.frame;

    // R1
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_idx) |-> $past(take));

    // R7
    block_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_wrap |=> (frame_idx == '0));

endmodule

// File: rtl/aes_cs_crc.sv
module aes_cs_crc #(
    parameter int          BLOCK_FRAMES = 192,
    parameter int          CRC_START    = 184,
    parameter int          CRC_W        = 8,
    parameter logic [7:0]  CRC_POLY     = 8'h1D,
    localparam int FW = $clog2(BLOCK_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic [FW-1:0]    frame_idx,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);

    localparam logic [CRC_W-1:0] CRC_INIT = '1;

    logic [CRC_W-1:0] crc_d, crc_q;
    logic             fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[CRC_W-1] ^ bit_in;
        if (clear) begin
            crc_d = CRC_INIT;
        end else if (step && (frame_idx < FW'(CRC_START))) begin
            crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY[CRC_W-1:0] : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= CRC_INIT;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R9
    crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc == CRC_INIT));

    // R9
    crc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && (frame_idx >= FW'(CRC_START))) |=> $stable(crc));

endmodule

// File: rtl/aes_bmc_encoder.sv
module aes_bmc_encoder
    import aes_tx_pkg::*;
#(
    parameter int SUB_HALVES = 64,
    localparam int SW = $clog2(SUB_HALVES),
    localparam int PW = $clog2(PRE_HALVES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SW-1:0]         half_idx,
    input  logic [PRE_HALVES-1:0] pattern,
    input  logic                  data_bit,
    output logic                  line
);

    typedef struct packed {
        logic line;
        logic pol;
    } enc_t;

    enc_t          st_d, st_q;
    logic          pol_now;
    logic [PW-1:0] pidx;

    always_comb begin
        st_d    = st_q;
        pol_now = (half_idx == '0) ? st_q.line : st_q.pol;
        pidx    = PW'(PRE_HALVES - 1) - half_idx[PW-1:0];
        if (half_idx < SW'(PRE_HALVES)) begin
            st_d.pol  = pol_now;
            st_d.line = pattern[pidx] ^ pol_now;
        end else if (!half_idx[0]) begin
            st_d.line = ~st_q.line;
        end else begin
            st_d.line = st_q.line ^ data_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line = st_q.line;

    // running count of ones over the data slots, checker only
    logic par_acc_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_acc_q <= 1'b0;
        end else if (half_idx[0] && (half_idx >= SW'(PRE_HALVES))) begin
            par_acc_q <= (half_idx[SW-1:1] == (SW-1)'(PRE_BITS)) ? data_bit
                                                                  : (par_acc_q ^ data_bit);
        end
    end

    // R4
    even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_idx == SW'(SUB_HALVES - 1)) |-> ((par_acc_q ^ data_bit) == 1'b0));

    // R5
    cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((half_idx >= SW'(PRE_HALVES)) && !half_idx[0]) |=> (line != $past(line)));

    // R6
    preamble_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_idx == '0) |=> (line != $past(line)));

endmodule

// File: rtl/aes_subframe_tx.sv
module aes_subframe_tx
    import aes_tx_pkg::*;
#(
    parameter int AUDIO_W      = 24,
    parameter int WORD_MIN     = 16,
    parameter int BLOCK_FRAMES = 192,
    parameter int CRC_START    = 184,
    localparam int WLW          = $clog2(AUDIO_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pro_mode,
    input  logic               crc_en,
    input  logic [WLW-1:0]     word_len,
    input  logic [AUDIO_W-1:0] left_sample,
    input  logic [AUDIO_W-1:0] right_sample,
    input  logic               left_valid,
    input  logic               right_valid,
    input  logic               left_user,
    input  logic               right_user,
    input  logic               cs_bit,
    output logic               sample_take,
    output logic               line_p,
    output logic               line_n
);

    localparam int SUB_BITS     = PRE_BITS + AUDIO_W + AUX_BITS;
    localparam int SUB_HALVES   = 2 * SUB_BITS;
    localparam int FRAME_HALVES = 2 * SUB_HALVES;
    localparam int HW           = $clog2(FRAME_HALVES);
    localparam int SW           = $clog2(SUB_HALVES);
    localparam int BW           = $clog2(SUB_BITS);
    localparam int FW           = $clog2(BLOCK_FRAMES);
    localparam int CRC_W        = 8;
    localparam int CW           = $clog2(CRC_W);
    localparam int POS_V        = PRE_BITS + AUDIO_W;
    localparam int POS_U        = POS_V + 1;
    localparam int POS_C        = POS_V + 2;

    typedef struct packed {
        logic [AUDIO_W-1:0] aud_l;
        logic [AUDIO_W-1:0] aud_r;
        logic               v_l;
        logic               v_r;
        logic               u_l;
        logic               u_r;
        logic               cs;
    } hold_t;

    hold_t hold_d, hold_q;

    logic [HW-1:0]      half_cnt;
    logic [FW-1:0]      frame_idx;
    logic               take;
    logic               block_wrap;
    logic [CRC_W-1:0]   crc_val;
    logic               line;

    logic [WLW-1:0]     wl_eff;
    logic [AUDIO_W-1:0] keep_mask;
    logic               sub;
    logic [SW-1:0]      sub_half;
    logic [BW-1:0]      bitpos;
    logic [BW-1:0]      aidx;
    logic [CW-1:0]      cidx;
    logic [AUDIO_W-1:0] cur_aud;
    logic               cur_v;
    logic               cur_u;
    logic               c_eff;
    logic               par;
    logic               data_bit;
    pre_kind_e          kind;
    logic [PRE_HALVES-1:0] pattern;

    aes_frame_timer #(
        .FRAME_HALVES (FRAME_HALVES),
        .BLOCK_FRAMES (BLOCK_FRAMES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_cnt   (half_cnt),
        .frame_idx  (frame_idx),
        .take       (take),
        .block_wrap (block_wrap)
    );

    aes_cs_crc #(
        .BLOCK_FRAMES (BLOCK_FRAMES),
        .CRC_START    (CRC_START),
        .CRC_W        (CRC_W)
    ) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (take),
        .clear     (block_wrap),
        .frame_idx (frame_idx),
        .bit_in    (c_eff),
        .crc       (crc_val)
    );

    aes_bmc_encoder #(
        .SUB_HALVES (SUB_HALVES)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_idx (sub_half),
        .pattern  (pattern),
        .data_bit (data_bit),
        .line     (line)
    );

    always_comb begin
        hold_d = hold_q;

        // word-length clamp and LSB mask
        if (word_len < WLW'(WORD_MIN))      wl_eff = WLW'(WORD_MIN);
        else if (word_len > WLW'(AUDIO_W))  wl_eff = WLW'(AUDIO_W);
        else                                wl_eff = word_len;
        for (int i = 0; i < AUDIO_W; i++) begin
            keep_mask[i] = (i >= (AUDIO_W - int'(wl_eff)));
        end

        if (take) begin
            hold_d.aud_l = left_sample & keep_mask;
            hold_d.aud_r = right_sample & keep_mask;
            hold_d.v_l   = left_valid;
            hold_d.v_r   = right_valid;
            hold_d.u_l   = left_user;
            hold_d.u_r   = right_user;
            hold_d.cs    = cs_bit;
        end

        // slot selection
        sub      = half_cnt[HW-1];
        sub_half = half_cnt[SW-1:0];
        bitpos   = sub_half[SW-1:1];
        aidx     = bitpos - BW'(PRE_BITS);
        cidx     = CW'(frame_idx - FW'(CRC_START));

        cur_aud  = sub ? hold_q.aud_r : hold_q.aud_l;
        cur_v    = sub ? hold_q.v_r   : hold_q.v_l;
        cur_u    = sub ? hold_q.u_r   : hold_q.u_l;

        if (frame_idx == '0)
            c_eff = pro_mode;
        else if (pro_mode && crc_en && (frame_idx >= FW'(CRC_START)))
            c_eff = crc_val[cidx];
        else
            c_eff = hold_q.cs;

        par = ^{cur_aud, cur_v, cur_u, c_eff};

        if (bitpos < BW'(POS_V))       data_bit = cur_aud[aidx];
        else if (bitpos == BW'(POS_V)) data_bit = cur_v;
        else if (bitpos == BW'(POS_U)) data_bit = cur_u;
        else if (bitpos == BW'(POS_C)) data_bit = c_eff;
        else                           data_bit = par;

        if (sub)                  kind = PRE_RIGHT;
        else if (frame_idx == '0) kind = PRE_BLOCK;
        else                      kind = PRE_LEFT;
        pattern = preamble_pattern(kind);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign sample_take = take;
    assign line_p      = line;
    assign line_n      = ~line;

    // R8
    status_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((frame_idx == '0) && (bitpos == BW'(POS_C))) |-> (data_bit == pro_mode));

endmodule

// File: tb/sim_aes_subframe_tx.sv
module sim_aes_subframe_tx;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pro_mode, crc_en;
    logic [4:0]  word_len;
    logic [23:0] left_sample, right_sample;
    logic        left_valid, right_valid, left_user, right_user, cs_bit;
    logic        sample_take, line_p, line_n;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    aes_subframe_tx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .pro_mode     (pro_mode),
        .crc_en       (crc_en),
        .word_len     (word_len),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .left_valid   (left_valid),
        .right_valid  (right_valid),
        .left_user    (left_user),
        .right_user   (right_user),
        .cs_bit       (cs_bit),
        .sample_take  (sample_take),
        .line_p       (line_p),
        .line_n       (line_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---- stimulus per frame number (frame 0 after reset carries zeros) ----
    function automatic logic [23:0] st_l(int n);
        logic [31:0] t = 32'(n) * 32'h9E37_79B1 ^ 32'h00A5_C35A;
        return t[23:0];
    endfunction
    function automatic logic [23:0] st_r(int n);
        logic [31:0] t = 32'(n) * 32'h85EB_CA6B ^ 32'h003C_5A96;
        return t[27:4];
    endfunction
    function automatic logic [4:0] st_wl(int n);
        int i = n % 11;
        if (i == 0)  return 5'd12;
        if (i == 10) return 5'd30;
        return 5'(15 + i);
    endfunction
    function automatic logic st_vl(int n); return n[0];          endfunction
    function automatic logic st_vr(int n); return n[1] ^ n[2];   endfunction
    function automatic logic st_ul(int n); return n[2];          endfunction
    function automatic logic st_ur(int n); return n[0] ^ n[3];   endfunction
    function automatic logic st_cs(int n); return ((n * 7) % 5) < 2; endfunction

    function automatic logic [23:0] keep(logic [4:0] wl);
        int w = (wl < 16) ? 16 : (wl > 24) ? 24 : int'(wl);
        logic [23:0] m = '0;
        for (int i = 0; i < 24; i++) m[i] = (i >= 24 - w);
        return m;
    endfunction

    task automatic driver(input int nframes);
        int m = 1;
        while (m < nframes) begin
            @(negedge clk);
            if (sample_take) begin
                left_sample  = st_l(m);
                right_sample = st_r(m);
                word_len     = st_wl(m);
                left_valid   = st_vl(m);
                right_valid  = st_vr(m);
                left_user    = st_ul(m);
                right_user   = st_ur(m);
                cs_bit       = st_cs(m);
                m++;
            end
        end
    endtask

    task automatic monitor(input int nframes);
        logic       h [128];
        logic       prev = line_p;
        logic [7:0] crc_m = 8'hFF;
        for (int m = 0; m < nframes; m++) begin
            int   fi = m % 192;
            bit   comp_ok = 1'b1;
            bit   take_ok = 1'b1;
            logic c_exp;
            string creq;
            for (int k = 0; k < 128; k++) begin
                @(posedge clk);
                @(negedge clk);
                h[k] = line_p;
                if (line_n !== ~line_p) comp_ok = 1'b0;
                if (sample_take !== (k == 126)) take_ok = 1'b0;
            end
            chk(comp_ok, "R12", "line_n complement", 0, 0);
            chk(take_ok, "R1", "sample_take position", int'(take_ok), 1);

            if (fi == 0) crc_m = 8'hFF;
            if (fi == 0)
                c_exp = pro_mode;
            else if (pro_mode && crc_en && fi >= 184)
                c_exp = crc_m[fi-184];
            else
                c_exp = (m == 0) ? 1'b0 : st_cs(m);
            if (fi == 0)       creq = "R8";
            else if (fi < 184) creq = "R7";
            else if (pro_mode && crc_en) creq = "R9";
            else               creq = "R10";

            for (int s = 0; s < 2; s++) begin
                int          b0 = 64 * s;
                logic        p0 = (s == 0) ? prev : h[63];
                logic [7:0]  pat;
                bit          pre_ok = 1'b1;
                bit          tr_ok = 1'b1;
                logic [31:0] bits = '0;
                logic [23:0] aud_exp;
                logic        v_exp, u_exp, par_exp;
                if (s == 1)       pat = 8'b1110_0100;
                else if (fi == 0) pat = 8'b1110_1000;
                else              pat = 8'b1110_0010;
                for (int k = 0; k < 8; k++)
                    if (h[b0+k] !== (pat[7-k] ^ p0)) pre_ok = 1'b0;
                chk(pre_ok, (fi == 0 && s == 0 && m == 0) ? "R11" : "R6",
                    "preamble pattern", m, s);
                for (int b = 4; b < 32; b++) begin
                    if (h[b0+2*b] === h[b0+2*b-1]) tr_ok = 1'b0;
                    bits[b] = h[b0+2*b] ^ h[b0+2*b+1];
                end
                chk(tr_ok, "R5", "cell-start transition", m, s);

                if (m == 0) begin
                    aud_exp = '0; v_exp = 1'b0; u_exp = 1'b0;
                end else begin
                    aud_exp = ((s == 0) ? st_l(m) : st_r(m)) & keep(st_wl(m));
                    v_exp   = (s == 0) ? st_vl(m) : st_vr(m);
                    u_exp   = (s == 0) ? st_ul(m) : st_ur(m);
                end
                par_exp = ^{aud_exp, v_exp, u_exp, c_exp};
                chk(bits[27:4] == aud_exp, (m == 0) ? "R11" : "R3", "audio field",
                    int'(bits[27:4]), int'(aud_exp));
                chk(bits[28] == v_exp, "R2", "validity slot", int'(bits[28]), int'(v_exp));
                chk(bits[29] == u_exp, "R2", "user slot", int'(bits[29]), int'(u_exp));
                chk(bits[30] == c_exp, creq, "status slot", int'(bits[30]), int'(c_exp));
                chk(bits[31] == par_exp, "R4", "parity slot", int'(bits[31]), int'(par_exp));
            end

            if (fi < 184) crc_m = {crc_m[6:0], 1'b0} ^ ((crc_m[7] ^ c_exp) ? 8'h1D : 8'h00);
            prev = h[127];
        end
    endtask

    task automatic run_phase(input logic pro, input logic cen, input int nframes);
        rst_n = 1'b0;
        pro_mode = pro; crc_en = cen;
        word_len = 5'd24; left_sample = '0; right_sample = '0;
        left_valid = 0; right_valid = 0; left_user = 0; right_user = 0; cs_bit = 0;
        repeat (3) @(negedge clk);
        // R11
        chk(line_p == 1'b0, "R11", "line_p in reset", int'(line_p), 0);
        chk(line_n == 1'b1, "R11", "line_n in reset", int'(line_n), 1);
        chk(sample_take == 1'b0, "R11", "sample_take in reset", int'(sample_take), 0);
        rst_n = 1'b1;
        fork
            driver(nframes);
            monitor(nframes);
        join
    endtask

    initial begin
        run_phase(1'b1, 1'b1, 386);
        run_phase(1'b0, 1'b1, 194);
        run_phase(1'b1, 1'b0, 194);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule